// File: doc/BRIEF.md
# Cell-Exchange Write-Back Line Cache

This block is a secondary cache that sits between a processor's load/store port and a cell-switched interconnect. It holds 32-byte lines and writes them back only when they are evicted. The storage is split into fixed regions, and each region covers its own 1 MiB window of remote memory. Within a region the lines are direct mapped. A hit is answered in the cycle the request is presented.

On a miss the block builds one 48-byte request cell and sends it to a remote memory node. The cell carries the line-aligned fetch address. When the line being replaced is dirty, the same cell also carries that line's write-back address and its 32 bytes of data. The processor stays stalled until a reply cell arrives on the reply circuit with a matching line address. That reply fills the line. The interconnect either delivers a cell or tells the sender that delivery failed, and a failure makes the block send the held request again.

A region may be chosen at build time as the endpoint of an incoming data stream. Cells that arrive on that region's circuit are written straight into its lines, with no processor request involved.

Top module: `cell_wb_cache`

## Requirements
- R1: After reset `tx_valid` is low, `err_cnt` is 0 and every line is invalid, so the first access to any address misses.
- R2: A processor read that hits raises `cpu_ready` combinationally in the same cycle. `cpu_rdata` is word `cpu_addr[4:2]`, where word k occupies line bits [255-32k -: 32].
- R3: A miss whose victim is invalid or clean produces exactly one request cell. Byte 0 (bits 383:376) is the opcode 0x00. Bits 375:344 hold the line-aligned fetch address. The write-back address (343:312), the data field (311:56) and the pad (55:0) are all zero.
- R4: A processor write hit completes in the same cycle and marks the line dirty. When that line is later evicted, the opcode is 0x01 and bits 343:312 carry the victim's line address. The data field carries the line including the written word.
- R5: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_cell` stays unchanged.
- R6: During a miss `cpu_ready` stays low until a reply arrives on circuit `REPLY_CIRC` whose address (bits 375:344, compared on bits 31:5) matches the outstanding miss. The fill leaves the line valid and clean, and the access then completes.
- R7: A cell on `REPLY_CIRC` that is not a matching reply to the outstanding miss is dropped and increments `err_cnt`, which saturates at 255. Cells on unrelated circuits leave `err_cnt` unchanged.
- R8: A `tx_fail` pulse while the block waits for a reply makes it raise `tx_valid` again with the identical cell.
- R9: A cell on circuit `STREAM_BASE + r`, where region r is flagged in `STREAM_MASK`, writes line `{r, addr[6:5]}` with tag `addr[19:7]`, valid and clean. The same cell on the circuit of an unflagged region has no effect.
- R10: The region index is `cpu_addr[20]`, the line index within the region is `cpu_addr[6:5]` and the tag is `cpu_addr[19:7]`. Two addresses that differ in region never evict each other.
- R11: In a cycle in which a stream cell is written, a processor access is not completed. `cpu_ready` rises in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor access request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address of the access |
| cpu_wdata | input | 32 | Write word |
| cpu_rdata | output | 32 | Read word, valid with `cpu_ready` |
| cpu_ready | output | 1 | Access completes this cycle |
| tx_valid | output | 1 | Request cell offered to the interconnect |
| tx_ready | input | 1 | Interconnect accepts the cell |
| tx_cell | output | 384 | Request cell payload, big-endian |
| tx_fail | input | 1 | Delivery failure of the last sent cell |
| rx_valid | input | 1 | Incoming cell present |
| rx_circ | input | 8 | Circuit number of the incoming cell |
| rx_cell | input | 384 | Incoming cell payload |
| err_cnt | output | 8 | Saturating count of dropped replies |

## Verification
The embedded properties check the following on every cycle:
- A held request cell does not change while it waits to be accepted (R5).
- A failure while waiting re-offers the same cell (R8).
- A write hit leaves its line dirty (R4).
- A fill leaves its line valid and clean (R6).
- The error count moves only when a cell arrives (R7).

Some behaviours depend on whole sequences of cells and addresses, so only the directed scenarios can show them:
- The exact byte layout of clean and dirty request cells (R3, R4).
- The rejection of a mismatched reply (R6, R7).
- Saturation of the error count (R7).
- Isolation between regions (R10).
- Stream writes into flagged regions only (R9).
- The one-cycle stall on a stream collision (R11).

// File: rtl/cell_wb_cache.sv
module cell_wb_cache #(
  parameter int NREG = 2,
  parameter int LPR = 4,
  parameter int CIRC_W = 8,
  parameter logic [CIRC_W-1:0] REPLY_CIRC = 8'd1,
  parameter logic [CIRC_W-1:0] STREAM_BASE = 8'd16,
  parameter logic [NREG-1:0] STREAM_MASK = 2'b10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [31:0]       cpu_addr,
  input  logic [31:0]       cpu_wdata,
  output logic [31:0]       cpu_rdata,
  output logic              cpu_ready,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [383:0]      tx_cell,
  input  logic              tx_fail,
  input  logic              rx_valid,
  input  logic [CIRC_W-1:0] rx_circ,
  input  logic [383:0]      rx_cell,
  output logic [7:0]        err_cnt
);
  localparam int LINE_W = 256;
  localparam int CELL_W = 384;
  localparam int RGN_W  = $clog2(NREG);
  localparam int IDX_W  = $clog2(LPR);
  localparam int TAG_W  = 15 - IDX_W;
  localparam int NL     = NREG * LPR;
  localparam int LN_W   = RGN_W + IDX_W;
  localparam int A_HI   = CELL_W - 9;
  localparam int D_HI   = CELL_W - 73;

  typedef enum logic [1:0] {S_IDLE, S_SEND, S_WAIT} st_t;
  st_t st;

  logic [NL-1:0]     vld, dty;
  logic [TAG_W-1:0]  tag_q  [NL];
  logic [LINE_W-1:0] line_q [NL];
  logic [CELL_W-1:0] cell_q;
  logic [26:0]       miss_la;
  logic [LN_W-1:0]   m_ln;
  logic [TAG_W-1:0]  m_tag;
  logic [7:0]        err_q;

  wire [RGN_W-1:0] c_rgn = cpu_addr[20 +: RGN_W];
  wire [IDX_W-1:0] c_idx = cpu_addr[5 +: IDX_W];
  wire [LN_W-1:0]  c_ln  = {c_rgn, c_idx};
  wire [TAG_W-1:0] c_tag = cpu_addr[19 -: TAG_W];
  wire [2:0]       c_wd  = cpu_addr[4:2];
  wire             c_hit = vld[c_ln] && (tag_q[c_ln] == c_tag);

  wire [31:0]       rx_a   = rx_cell[A_HI -: 32];
  wire [LINE_W-1:0] rx_d   = rx_cell[D_HI -: LINE_W];
  wire [CIRC_W-1:0] s_off  = rx_circ - STREAM_BASE;
  wire [RGN_W-1:0]  s_rgn  = s_off[RGN_W-1:0];
  wire              s_in   = s_off < CIRC_W'(NREG);
  wire              s_wr   = rx_valid && s_in && STREAM_MASK[s_rgn];
  wire [LN_W-1:0]   s_ln   = {s_rgn, rx_a[5 +: IDX_W]};
  wire              reply  = rx_valid && (rx_circ == REPLY_CIRC);
  wire              fill   = reply && (st == S_WAIT) && (rx_a[31:5] == miss_la);
  wire              drop   = reply && !fill;

  wire        idle_req = cpu_req && (st == S_IDLE) && !s_wr;
  wire        miss_go  = idle_req && !c_hit;
  wire        v_wb     = vld[c_ln] && dty[c_ln];
  wire [31:0] f_addr   = 32'({c_rgn, cpu_addr[19:5], 5'b0});
  wire [31:0] w_addr   = v_wb ? 32'({c_rgn, tag_q[c_ln], c_idx, 5'b0}) : 32'h0;
  wire [LINE_W-1:0] w_line = v_wb ? line_q[c_ln] : '0;

  assign cpu_ready = idle_req && c_hit;
  assign cpu_rdata = line_q[c_ln][LINE_W-1-32*c_wd -: 32];
  assign tx_valid  = (st == S_SEND);
  assign tx_cell   = cell_q;
  assign err_cnt   = err_q;

  wire unused_bits = ^{rx_cell[CELL_W-1 -: 8], rx_cell[A_HI-32 -: 32], rx_cell[55:0],
                       cpu_addr[31:20+RGN_W], cpu_addr[1:0], s_off};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      vld     <= '0;
      dty     <= '0;
      err_q   <= '0;
      cell_q  <= '0;
      miss_la <= '0;
      m_ln    <= '0;
      m_tag   <= '0;
    end else begin
      case (st)
        S_IDLE: if (miss_go) begin
          cell_q  <= {7'b0, v_wb, f_addr, w_addr, w_line, 56'b0};
          miss_la <= f_addr[31:5];
          m_ln    <= c_ln;
          m_tag   <= c_tag;
          st      <= S_SEND;
        end
        S_SEND: if (tx_ready) st <= S_WAIT;
        S_WAIT: if (fill) st <= S_IDLE;
                else if (tx_fail) st <= S_SEND;
        default: st <= S_IDLE;
      endcase
      if (fill) begin
        vld[m_ln] <= 1'b1;
        dty[m_ln] <= 1'b0;
      end else if (s_wr) begin
        vld[s_ln] <= 1'b1;
        dty[s_ln] <= 1'b0;
      end
      if (cpu_ready && cpu_we) dty[c_ln] <= 1'b1;
      if (drop && err_q != 8'hFF) err_q <= err_q + 8'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill) begin
      line_q[m_ln] <= rx_d;
      tag_q[m_ln]  <= m_tag;
    end else if (s_wr) begin
      line_q[s_ln] <= rx_d;
      tag_q[s_ln]  <= rx_a[19 -: TAG_W];
    end
    if (cpu_ready && cpu_we) line_q[c_ln][LINE_W-1-32*c_wd -: 32] <= cpu_wdata;
  end

  p_cell_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_cell));
  p_resend_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT) && tx_fail && !fill |=> tx_valid && $stable(tx_cell));
  p_fill_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fill |=> vld[$past(m_ln)] && !dty[$past(m_ln)]);
  p_wr_dirty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready && cpu_we |=> dty[$past(c_ln)]);
  p_err_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> $stable(err_cnt));
endmodule

// File: tb/cell_wb_cache_tb.sv
module cell_wb_cache_tb_top;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0;
  logic cpu_req = 0, cpu_we = 0;
  logic [31:0] cpu_addr = 0, cpu_wdata = 0, cpu_rdata;
  logic cpu_ready, tx_valid, tx_ready = 0, tx_fail = 0, rx_valid = 0;
  logic [383:0] tx_cell, rx_cell = 0;
  logic [7:0] rx_circ = 0, err_cnt;
  int n_run = 0, n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  cell_wb_cache dut_i (.*);

  initial begin
    #(CLK_P * 20000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic chk(input bit ok, input string req, input logic [383:0] act, exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [255:0] mk_line(input logic [31:0] seed);
    logic [255:0] l;
    for (int k = 0; k < 8; k++) l[255-32*k -: 32] = seed + 32'(k);
    return l;
  endfunction

  function automatic logic [31:0] word_of(input logic [255:0] l, input logic [31:0] a);
    return l[255-32*int'(a[4:2]) -: 32];
  endfunction

  function automatic logic [383:0] req_cell(input bit wb, input logic [31:0] fa, wa,
                                            input logic [255:0] d);
    return {7'b0, wb, fa, wa, d, 56'b0};
  endfunction

  function automatic logic [383:0] rep_cell(input logic [31:0] a, input logic [255:0] d);
    return {8'h0, a, 32'h0, d, 56'h0};
  endfunction

  task automatic send_rx(input logic [7:0] circ, input logic [383:0] c);
    rx_valid = 1; rx_circ = circ; rx_cell = c;
    tick();
    rx_valid = 0;
    #1;
  endtask

  task automatic do_miss(input logic [31:0] a, input logic [383:0] exp, input logic [255:0] d,
                         input string req);
    cpu_req = 1; cpu_we = 0; cpu_addr = a; #1;
    chk(!cpu_ready, {req, " miss not ready"}, 384'(cpu_ready), 0);
    tick();
    chk(tx_valid && tx_cell == exp, {req, " request cell"}, tx_cell, exp);
    tx_ready = 1; tick(); tx_ready = 0; #1;
    send_rx(8'd1, rep_cell({a[31:5], 5'b0}, d));
    chk(cpu_ready && cpu_rdata == word_of(d, a), {req, " read after fill"},
        384'(cpu_rdata), 384'(word_of(d, a)));
    cpu_req = 0; #1;
  endtask

  logic [255:0] la, lb, lc, ls, lz;

  task automatic t_reset();
    chk(!tx_valid && err_cnt == 0, "R1 reset state", 384'({tx_valid, err_cnt}), 0);
  endtask

  task automatic t_first_miss();
    logic [383:0] e;
    la = mk_line(32'hA000_0000);
    e = req_cell(0, 32'h40, 0, '0);
    cpu_req = 1; cpu_addr = 32'h40; #1;
    chk(!cpu_ready, "R1 empty cache misses", 384'(cpu_ready), 0);
    tick();
    chk(tx_valid && tx_cell == e, "R3 clean request cell", tx_cell, e);
    tick();
    chk(tx_valid && tx_cell == e, "R5 cell held without tx_ready", tx_cell, e);
    tx_ready = 1; tick(); tx_ready = 0; #1;
    chk(!tx_valid && !cpu_ready, "R6 stalled while waiting", 384'({tx_valid, cpu_ready}), 0);
    send_rx(8'd1, rep_cell(32'h60, la));
    chk(err_cnt == 1 && !cpu_ready, "R7 mismatched reply dropped", 384'({err_cnt, cpu_ready}),
        384'({8'd1, 1'b0}));
    tx_fail = 1; tick(); tx_fail = 0; #1;
    chk(tx_valid && tx_cell == e, "R8 resend after failure", tx_cell, e);
    tx_ready = 1; tick(); tx_ready = 0; #1;
    send_rx(8'd1, rep_cell(32'h40, la));
    chk(cpu_ready && cpu_rdata == word_of(la, 32'h40), "R6 ready after fill",
        384'(cpu_rdata), 384'(word_of(la, 32'h40)));
    cpu_addr = 32'h44; #1;
    chk(cpu_ready && cpu_rdata == word_of(la, 32'h44), "R2 read hit word1",
        384'(cpu_rdata), 384'(word_of(la, 32'h44)));
    cpu_req = 0; #1;
  endtask

  task automatic t_dirty_evict();
    cpu_req = 1; cpu_we = 1; cpu_addr = 32'h48; cpu_wdata = 32'hDEAD_BEEF; #1;
    chk(cpu_ready, "R4 write hit completes", 384'(cpu_ready), 1);
    tick();
    cpu_req = 0; cpu_we = 0;
    la[255-64 -: 32] = 32'hDEAD_BEEF;
    lb = mk_line(32'hB000_0000);
    do_miss(32'h240, req_cell(1, 32'h240, 32'h40, la), lb, "R4 dirty eviction");
  endtask

  task automatic t_regions();
    lc = mk_line(32'hC000_0000);
    do_miss(32'h0010_0040, req_cell(0, 32'h0010_0040, 0, '0), lc, "R10 other region");
    cpu_req = 1; cpu_addr = 32'h244; #1;
    chk(cpu_ready && cpu_rdata == word_of(lb, 32'h244), "R10 region0 line kept",
        384'(cpu_rdata), 384'(word_of(lb, 32'h244)));
    cpu_req = 0; #1;
  endtask

  task automatic t_stream();
    ls = mk_line(32'h5000_0000);
    send_rx(8'd17, rep_cell(32'h0010_0060, ls));
    cpu_req = 1; cpu_addr = 32'h0010_0064; #1;
    chk(cpu_ready && cpu_rdata == word_of(ls, 32'h64), "R9 stream cell filled line",
        384'(cpu_rdata), 384'(word_of(ls, 32'h64)));
    cpu_req = 0; #1;
    do_miss(32'h0010_01E0, req_cell(0, 32'h0010_01E0, 0, '0), mk_line(32'h7), "R9 stream line clean");
    lz = mk_line(32'h9000_0000);
    send_rx(8'd16, rep_cell(32'h0, lz));
    do_miss(32'h0, req_cell(0, 32'h0, 0, '0), lz, "R9 unflagged region ignored");
  endtask

  task automatic t_collide();
    cpu_req = 1; cpu_addr = 32'h240;
    rx_valid = 1; rx_circ = 8'd17; rx_cell = rep_cell(32'h0010_0000, ls); #1;
    chk(!cpu_ready, "R11 access held during stream write", 384'(cpu_ready), 0);
    tick(); rx_valid = 0; #1;
    chk(cpu_ready && cpu_rdata == word_of(lb, 32'h240), "R11 access completes next cycle",
        384'(cpu_rdata), 384'(word_of(lb, 32'h240)));
    cpu_req = 0; #1;
  endtask

  task automatic t_err_sat();
    send_rx(8'd5, rep_cell(32'h40, la));
    chk(err_cnt == 1, "R7 other circuit no count", 384'(err_cnt), 1);
    rx_valid = 1; rx_circ = 8'd1; rx_cell = rep_cell(32'h40, la);
    for (int i = 0; i < 260; i++) tick();
    rx_valid = 0; #1;
    chk(err_cnt == 8'hFF, "R7 error count saturates", 384'(err_cnt), 384'(8'hFF));
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1;
    #1;
    t_reset();
    t_first_miss();
    t_dirty_evict();
    t_regions();
    t_stream();
    t_collide();
    t_err_sat();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule